// File: doc/BRIEF.md
# Key-Guarded Commit Mask for Function Select

This block protects an 8-bit function-select register behind two layers of write control. A lock register must first receive a fixed 32-bit key. While the unit is unlocked, software may rewrite a commit mask. Each bit of that mask then acts as a write enable for the matching bit of the function-select register. Select bits whose mask bit is clear keep their value through any write.

The block sits on a simple synchronous register port. A write is one cycle with `bus_wr` high. A read is one cycle with `bus_rd` high, and its data appears on `bus_rdata` in the following cycle. The current selection is driven out continuously on `alt_sel` for the pin logic that consumes it. Addresses are byte offsets, and each register is decoded by a full match of `bus_addr`.

Top module: `commit_gate_regs`

## Requirements
- R1: After reset the unit is locked, the commit mask is 0xFF, the function select is 0x00 and `bus_rdata` is 0.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 unlocks the unit, and a read of offset 0x520 then returns 0.
- R3: A write of any other value to offset 0x520 locks the unit, including values that differ from the key in one bit, and a read of offset 0x520 then returns 1.
- R4: While locked, a write to the commit mask at offset 0x524 leaves the mask unchanged.
- R5: While unlocked, a write to offset 0x524 loads bits 7:0 of the write data into the commit mask. A read of offset 0x524 returns the mask, zero-extended, whether the unit is locked or not.
- R6: A write to offset 0x420 changes only the select bits whose commit-mask bit is 1. Every other select bit keeps its value.
- R7: A read of offset 0x420 returns the function select, zero-extended, and `alt_sel` always equals the register.
- R8: The unlocked state lasts through any number of other reads and writes until a lock-register write carries a non-key value.
- R9: A read of any unmapped offset returns 0, and a write to one changes no register.
- R10: Read data appears on `bus_rdata` one cycle after the read request. In any cycle that follows a cycle without a read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| alt_sel | output | 8 | Current function-select value |

## Verification
The bench targets the key comparison at its edges. It writes values one bit away from the key, and it writes zero. A comparator that checks only part of the word, or that treats any nonzero value as the key, would unlock on one of these. It writes the commit mask while locked and reads it back afterwards, which exposes a design that ignores the lock. It uses several sparse mask patterns against the function-select writes, so a design that applies the mask inverted or writes every bit produces a wrong readback and a wrong `alt_sel`. It runs a mix of unrelated and unmapped accesses after unlocking, which catches an unlock that lapses on its own or an address decode that aliases.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam logic [31:0] CGR_KEY        = 32'h0ACC_E551;
    localparam logic [11:0] CGR_SEL_OFS    = 12'h420;
    localparam logic [11:0] CGR_LOCK_OFS   = 12'h520;
    localparam logic [11:0] CGR_COMMIT_OFS = 12'h524;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_SEL    = 2'd1,
        HIT_LOCK   = 2'd2,
        HIT_COMMIT = 2'd3
    } cgr_hit_e;

    typedef struct packed {
        logic locked;
    } cgr_lock_st_t;

endpackage

// File: rtl/cgr_lock_unit.sv
module cgr_lock_unit import cgr_pkg::*; #(
    parameter int               DATA_W     = 32,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = CGR_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);

    cgr_lock_st_t st_d;
    cgr_lock_st_t st_q;
    logic         key_match;

    // Full-width equality, so a single wrong bit keeps the unit locked.
    assign key_match = (wdata == UNLOCK_KEY);

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.locked = ~key_match;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

endmodule

// File: rtl/cgr_commit_reg.sv
module cgr_commit_reg #(
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             locked,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] commit
);

    typedef struct packed {
        logic [SEL_W-1:0] mask;
    } commit_st_t;

    commit_st_t st_d;
    commit_st_t st_q;

    always_comb begin
        st_d = st_q;
        // A locked unit drops the write without any response.
        if (wr_hit && !locked) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit = st_q.mask;

endmodule

// File: rtl/cgr_masked_reg.sv
module cgr_masked_reg #(
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [SEL_W-1:0] commit,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel
);

    typedef struct packed {
        logic [SEL_W-1:0] bits;
    } sel_st_t;

    sel_st_t          st_d;
    sel_st_t          st_q;
    logic [SEL_W-1:0] bit_nxt;

    // One write-enable cell per select bit.
    for (genvar i = 0; i < SEL_W; i++) begin : g_bit
        assign bit_nxt[i] = (wr_hit && commit[i]) ? wdata[i] : st_q.bits[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.bits;

endmodule

// File: rtl/commit_gate_regs.sv
module commit_gate_regs import cgr_pkg::*; #(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter int                SEL_W      = 8,
    parameter logic [ADDR_W-1:0] SEL_OFS    = CGR_SEL_OFS,
    parameter logic [ADDR_W-1:0] LOCK_OFS   = CGR_LOCK_OFS,
    parameter logic [ADDR_W-1:0] COMMIT_OFS = CGR_COMMIT_OFS,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = CGR_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  alt_sel
);

    localparam int PAD_W = DATA_W - SEL_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    cgr_hit_e          hit;
    logic              lock_state;
    logic [SEL_W-1:0]  commit_mask;
    logic [SEL_W-1:0]  sel_value;
    logic [DATA_W-1:0] rd_value;
    rd_st_t            rd_d;
    rd_st_t            rd_q;

    // Address decode, full match on every offset bit.
    always_comb begin
        if (bus_addr == SEL_OFS) begin
            hit = HIT_SEL;
        end else if (bus_addr == LOCK_OFS) begin
            hit = HIT_LOCK;
        end else if (bus_addr == COMMIT_OFS) begin
            hit = HIT_COMMIT;
        end else begin
            hit = HIT_NONE;
        end
    end

    cgr_lock_unit #(
        .DATA_W     (DATA_W),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_wr && (hit == HIT_LOCK)),
        .wdata  (bus_wdata),
        .locked (lock_state)
    );

    cgr_commit_reg #(
        .SEL_W (SEL_W)
    ) u_commit (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_wr && (hit == HIT_COMMIT)),
        .locked (lock_state),
        .wdata  (bus_wdata[SEL_W-1:0]),
        .commit (commit_mask)
    );

    cgr_masked_reg #(
        .SEL_W (SEL_W)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_wr && (hit == HIT_SEL)),
        .commit (commit_mask),
        .wdata  (bus_wdata[SEL_W-1:0]),
        .sel    (sel_value)
    );

    // Readback selection; the lock word reports 1 while locked.
    always_comb begin
        case (hit)
            HIT_SEL:    rd_value = {{PAD_W{1'b0}}, sel_value};
            HIT_COMMIT: rd_value = {{PAD_W{1'b0}}, commit_mask};
            HIT_LOCK:   rd_value = {{(DATA_W-1){1'b0}}, lock_state};
            default:    rd_value = '0;
        endcase
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.rdata = bus_rd ? rd_value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
    assign alt_sel   = sel_value;

endmodule

// File: rtl/commit_gate_regs_chk.sv
module commit_gate_regs_chk #(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter int                SEL_W      = 8,
    parameter logic [ADDR_W-1:0] LOCK_OFS   = 12'h520,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SEL_W-1:0]  alt_sel,
    input logic              locked,
    input logic [SEL_W-1:0]  commit
);

    logic lock_wr;
    assign lock_wr = bus_wr && (bus_addr == LOCK_OFS);

    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && (bus_wdata == UNLOCK_KEY)) |=> !locked);  // R2

    AST_NONKEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && (bus_wdata != UNLOCK_KEY)) |=> locked);  // R3

    AST_LOCKED_COMMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(commit));  // R4

    AST_SEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((alt_sel ^ $past(alt_sel)) & ~$past(commit)) == '0));  // R6

    AST_UNLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !lock_wr) |=> !locked);  // R8

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));  // R10

endmodule

bind commit_gate_regs commit_gate_regs_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W),
    .LOCK_OFS   (LOCK_OFS),
    .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alt_sel   (alt_sel),
    .locked    (lock_state),
    .commit    (commit_mask)
);

// File: tb/commit_gate_regs_test.sv
module commit_gate_regs_test;

    localparam logic [11:0] A_SEL    = 12'h420;
    localparam logic [11:0] A_LOCK   = 12'h524 - 12'h4;
    localparam logic [11:0] A_COMMIT = 12'h524;
    localparam logic [31:0] KEY      = 32'h0ACC_E551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  alt_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] m_sel;
    logic [7:0] m_commit;

    always #10 clk = ~clk;

    commit_gate_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alt_sel   (alt_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 alt_sel", {24'h0, alt_sel}, 32'h0);
        do_read(A_LOCK, v);   check("R1 lock", v, 32'h1);
        do_read(A_COMMIT, v); check("R1 commit", v, 32'hFF);
        do_read(A_SEL, v);    check("R1 sel", v, 32'h0);
    endtask

    task automatic t_locked_commit();
        logic [31:0] v;
        do_write(A_COMMIT, 32'h0000_0012);
        do_read(A_COMMIT, v); check("R4 commit ignored", v, {24'h0, m_commit});
        do_write(A_LOCK, KEY ^ 32'h1);
        do_write(A_COMMIT, 32'h0000_0034);
        do_read(A_COMMIT, v); check("R3 near-key write keeps lock", v, {24'h0, m_commit});
        do_read(A_LOCK, v);   check("R3 lock read", v, 32'h1);
    endtask

    task automatic t_unlock_commit();
        logic [31:0] v;
        do_write(A_LOCK, KEY);
        do_read(A_LOCK, v); check("R2 unlocked read", v, 32'h0);
        do_write(A_COMMIT, 32'hFFFF_FF5A);
        m_commit = 8'h5A;
        do_read(A_COMMIT, v); check("R5 commit loaded", v, 32'h5A);
    endtask

    task automatic t_masked_sel(input logic [7:0] mask, input logic [7:0] wval);
        logic [31:0] v;
        do_write(A_COMMIT, {24'h0, mask});
        m_commit = mask;
        do_write(A_SEL, {24'hABCDEF, wval});
        m_sel = (m_sel & ~mask) | (wval & mask);
        check("R7 alt_sel port", {24'h0, alt_sel}, {24'h0, m_sel});
        do_read(A_SEL, v); check("R6 masked select", v, {24'h0, m_sel});
    endtask

    task automatic t_persist();
        logic [31:0] v;
        do_read(A_SEL, v);
        do_write(A_SEL, 32'h0);
        m_sel = m_sel & ~m_commit;
        do_write(12'h000, 32'hFFFF_FFFF);
        do_read(12'h7FC, v);
        do_write(A_COMMIT, 32'h0000_00C3);
        m_commit = 8'hC3;
        do_read(A_LOCK, v);   check("R8 still unlocked", v, 32'h0);
        do_read(A_COMMIT, v); check("R8 commit after traffic", v, 32'hC3);
    endtask

    task automatic t_relock();
        logic [31:0] v;
        do_write(A_LOCK, 32'h0);
        do_read(A_LOCK, v); check("R3 zero locks", v, 32'h1);
        do_write(A_COMMIT, 32'h0000_0001);
        do_read(A_COMMIT, v); check("R5 commit readable while locked", v, {24'h0, m_commit});
        do_write(A_LOCK, KEY ^ 32'h8000_0000);
        do_read(A_LOCK, v); check("R3 top-bit near key", v, 32'h1);
        do_write(A_LOCK, KEY);
        do_write(A_LOCK, 32'h0ACC_E552);
        do_read(A_LOCK, v); check("R3 relock after unlock", v, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_write(12'h41C, 32'hFFFF_FFFF);
        do_write(12'h528, 32'hFFFF_FFFF);
        do_write(12'hC20, 32'hFFFF_FFFF);
        do_read(12'h41C, v); check("R9 unmapped read 41C", v, 32'h0);
        do_read(12'h421, v); check("R9 unmapped read 421", v, 32'h0);
        do_read(12'hD20, v); check("R9 unmapped read D20", v, 32'h0);
        do_read(A_SEL, v);    check("R9 sel untouched", v, {24'h0, m_sel});
        do_read(A_COMMIT, v); check("R9 commit untouched", v, {24'h0, m_commit});
        do_read(A_LOCK, v);   check("R9 lock untouched", v, 32'h1);
    endtask

    task automatic t_read_timing();
        logic [31:0] v;
        do_read(A_COMMIT, v);
        check("R10 read data next cycle", v, {24'h0, m_commit});
        @(negedge clk);
        check("R10 idle rdata zero", bus_rdata, 32'h0);
    endtask

    initial begin
        m_sel    = 8'h00;
        m_commit = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked_commit();
        t_unlock_commit();
        t_masked_sel(8'h5A, 8'hFF);
        t_masked_sel(8'h81, 8'h00);
        t_masked_sel(8'h0F, 8'h36);
        t_masked_sel(8'h00, 8'hFF);
        t_persist();
        t_relock();
        t_unmapped();
        t_read_timing();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule